// File: doc/BRIEF.md
# Exception Entry Frame Sequencer

This block turns an exception request into the stack traffic a processor core performs on entry to a handler. A request carries an 8-bit vector number together with the interrupted context: stack segment and pointer, flags, code segment, instruction pointer, current privilege level and the fields that make up an error code. The block captures all of these when it accepts the request. It then looks the vector up in a small gate table that is set by parameters. Each entry says whether the gate is present, whether it is a 16-bit or a 32-bit gate, and whether the handler runs at ring 0 or ring 3.

If the gate is absent, the block retries through the general-protection vector (0x0D). It builds an error code that names the missing table entry. If that gate is also absent, it raises an abort and stops. For a present gate it emits one stack word per cycle. Each word comes with the address it is written to, which is the stack pointer after it has been decremented. When the handler's privilege level differs from the current one, the block switches to a supplied new stack and saves the old stack pointer on it first. At the end it reports the handler entry point and the final stack pointer through a done strobe.

Top module: `exc_frame_seq`

## Requirements
- R1: For a present gate, the pushed word order is EFLAGS, CS, EIP, and then the error code when R2 applies. When R5 applies, old SS and old ESP come before EFLAGS, in that order.
- R2: An error code is pushed only when the resolved vector is 0x08, 0x0A, 0x0B, 0x0C, 0x0D or 0x0E. Every other vector pushes no error code.
- R3: Before each write the stack pointer drops by 4 on a 32-bit gate and by 2 on a 16-bit gate. `push_addr` carries the decremented value, and `out_esp` at done equals the address of the last word pushed.
- R4: A 32-bit gate drives `push_wide`=1 and full 32-bit words. A 16-bit gate drives `push_wide`=0 and only the low 16 bits of each value (SP, FLAGS, IP), with the upper bits zero. Segment values are zero-extended.
- R5: When the handler ring (0 or 3, from the table) differs from `cur_cpl`, the frame is built on `new_sp`, and `out_ss` reports `new_ss`. Otherwise the frame is built on `cur_esp`, and `out_ss` reports `cur_ss`.
- R6: If the requested gate is absent, the block uses gate 0x0D instead. The error code it pushes has the original vector in bits 15:3, bit 2 = 0, bit 1 = 1 and bit 0 = `err_ext`.
- R7: Otherwise the error code has `err_idx` in bits 15:3, `err_ti` in bit 2, `err_int` in bit 1 and `err_ext` in bit 0, with bits 31:16 zero.
- R8: If gate 0x0D is absent when it is needed, `abort` pulses for one cycle with no pushes and no done, and the block returns to idle.
- R9: A request is accepted only while `busy` is low. `busy` stays high from acceptance until the done (or abort) cycle. Requests and input changes that arrive while busy have no effect on the frame in progress.
- R10: At done, `entry_cs` is `HCS_KERNEL` for a ring-0 handler or `HCS_USER` for a ring-3 handler, and `entry_eip` = `HANDLER_BASE + vector*HANDLER_STRIDE`, where vector is the resolved vector.
- R11: The saved EIP word is the instruction pointer captured at acceptance, unchanged, so that a faulting instruction can be restarted.
- R12: During reset and right after it, `busy`, `push_valid`, `done` and `abort` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request |
| req_vec | input | 8 | Requested vector |
| cur_cpl | input | 2 | Current privilege level |
| cur_ss | input | 16 | Current stack segment |
| cur_esp | input | 32 | Current stack pointer |
| cur_eflags | input | 32 | Current flags |
| cur_cs | input | 16 | Current code segment |
| cur_eip | input | 32 | Instruction pointer to save |
| err_idx | input | 13 | Error-code selector index |
| err_ti | input | 1 | Error-code table indicator (0 global, 1 local) |
| err_int | input | 1 | Error-code interrupt-table flag |
| err_ext | input | 1 | Error-code external-event flag |
| new_ss | input | 16 | Stack segment used on a privilege change |
| new_sp | input | 32 | Stack pointer used on a privilege change |
| busy | output | 1 | Request in progress |
| push_valid | output | 1 | Stack word valid this cycle |
| push_wide | output | 1 | 1 for a 32-bit word, 0 for a 16-bit word |
| push_addr | output | 32 | Address of the stack word |
| push_data | output | 32 | Stack word |
| done | output | 1 | Frame complete; entry point valid |
| abort | output | 1 | Unrecoverable missing gate |
| entry_cs | output | 16 | Handler code segment |
| entry_eip | output | 32 | Handler entry offset |
| out_ss | output | 16 | Stack segment of the finished frame |
| out_esp | output | 32 | Final stack pointer |

## Verification
All 32 low vectors are requested, with the current ring alternating between 0 and 3. This separates the error-code vectors from the rest, and frames built on the same stack from frames built on a new stack. Some of these gates are 16-bit and some are handler-at-ring-3 gates. These pairings tell word width and step size apart from the choice of stack. Vectors with absent gates, one of them above 0x1F, exercise the redirect code. A second instance that lacks gate 0x0D shows the abort path for both direct and redirected requests. In one run, a competing request and changed inputs are applied while the block is busy, which shows that the values captured at acceptance are kept.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int VEC_W   = 8;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam logic [VEC_W-1:0] GP_VEC = 8'h0D;

    typedef struct packed {
        logic        present;
        logic        is32;
        logic [1:0]  ring;
        logic [15:0] cs;
        logic [31:0] eip;
    } gate_t;

    typedef enum logic [2:0] {
        K_SS, K_SP, K_FLAGS, K_CS, K_IP, K_ERR, K_END
    } word_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RESOLVE, ST_PUSH, ST_DONE, ST_ABORT
    } seq_state_t;

    typedef struct packed {
        logic [1:0]  cpl;
        logic [15:0] ss;
        logic [31:0] esp;
        logic [31:0] eflags;
        logic [15:0] cs;
        logic [31:0] eip;
        logic [15:0] errcode;
        logic        ext;
        logic [15:0] nss;
        logic [31:0] nsp;
    } ctx_t;

    function automatic logic carries_errcode(input logic [VEC_W-1:0] v);
        case (v)
            8'h08, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E: return 1'b1;
            default:                                  return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] missing_gate_code(input logic [VEC_W-1:0] v,
                                                      input logic ext);
        return {{(13-VEC_W){1'b0}}, v, 1'b0, 1'b1, ext};
    endfunction

    function automatic word_kind_t following_kind(input word_kind_t k,
                                                  input logic with_err);
        case (k)
            K_SS:    return K_SP;
            K_SP:    return K_FLAGS;
            K_FLAGS: return K_CS;
            K_CS:    return K_IP;
            K_IP:    return with_err ? K_ERR : K_END;
            default: return K_END;
        endcase
    endfunction

endpackage

// File: rtl/exc_gate_rom.sv
module exc_gate_rom
    import exc_pkg::*;
#(
    parameter logic [NUM_VEC-1:0] ABSENT_MASK    = '0,
    parameter logic [NUM_VEC-1:0] NARROW_MASK    = '0,
    parameter logic [NUM_VEC-1:0] USER_MASK      = '0,
    parameter logic [15:0]        HCS_KERNEL     = 16'h0008,
    parameter logic [15:0]        HCS_USER       = 16'h001B,
    parameter logic [31:0]        HANDLER_BASE   = 32'h0000_4000,
    parameter logic [31:0]        HANDLER_STRIDE = 32'h0000_0010
) (
    input  logic [VEC_W-1:0] vec,
    output gate_t            gate
);
    always_comb begin
        gate.present = ~ABSENT_MASK[vec];
        gate.is32    = ~NARROW_MASK[vec];
        gate.ring    = USER_MASK[vec] ? 2'd3 : 2'd0;
        gate.cs      = USER_MASK[vec] ? HCS_USER : HCS_KERNEL;
        gate.eip     = HANDLER_BASE + (32'(vec) * HANDLER_STRIDE);
    end
endmodule

// File: rtl/exc_word_mux.sv
module exc_word_mux
    import exc_pkg::*;
(
    input  word_kind_t  kind,
    input  ctx_t        ctx,
    input  logic        wide,
    output logic [31:0] data
);
    logic [31:0] raw;

    always_comb begin
        case (kind)
            K_SS:    raw = {16'h0, ctx.ss};
            K_SP:    raw = ctx.esp;
            K_FLAGS: raw = ctx.eflags;
            K_CS:    raw = {16'h0, ctx.cs};
            K_IP:    raw = ctx.eip;
            K_ERR:   raw = {16'h0, ctx.errcode};
            default: raw = '0;
        endcase
        data = wide ? raw : {16'h0, raw[15:0]};
    end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_pkg::*;
#(
    parameter logic [NUM_VEC-1:0] ABSENT_MASK    = '0,
    parameter logic [NUM_VEC-1:0] NARROW_MASK    = '0,
    parameter logic [NUM_VEC-1:0] USER_MASK      = '0,
    parameter logic [15:0]        HCS_KERNEL     = 16'h0008,
    parameter logic [15:0]        HCS_USER       = 16'h001B,
    parameter logic [31:0]        HANDLER_BASE   = 32'h0000_4000,
    parameter logic [31:0]        HANDLER_STRIDE = 32'h0000_0010
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [7:0]  req_vec,
    input  logic [1:0]  cur_cpl,
    input  logic [15:0] cur_ss,
    input  logic [31:0] cur_esp,
    input  logic [31:0] cur_eflags,
    input  logic [15:0] cur_cs,
    input  logic [31:0] cur_eip,
    input  logic [12:0] err_idx,
    input  logic        err_ti,
    input  logic        err_int,
    input  logic        err_ext,
    input  logic [15:0] new_ss,
    input  logic [31:0] new_sp,
    output logic        busy,
    output logic        push_valid,
    output logic        push_wide,
    output logic [31:0] push_addr,
    output logic [31:0] push_data,
    output logic        done,
    output logic        abort,
    output logic [15:0] entry_cs,
    output logic [31:0] entry_eip,
    output logic [15:0] out_ss,
    output logic [31:0] out_esp
);
    localparam logic [31:0] STEP_WIDE   = 32'd4;
    localparam logic [31:0] STEP_NARROW = 32'd2;

    seq_state_t       state_q;
    ctx_t             ctx_q;
    logic [VEC_W-1:0] vec_q;
    gate_t            gate_q;
    gate_t            gate_lk;
    word_kind_t       kind_q;
    word_kind_t       kind_nx;
    logic             err_q;
    logic [31:0]      sp_q;
    logic [15:0]      fss_q;
    logic             ring_change;

    exc_gate_rom #(
        .ABSENT_MASK   (ABSENT_MASK),
        .NARROW_MASK   (NARROW_MASK),
        .USER_MASK     (USER_MASK),
        .HCS_KERNEL    (HCS_KERNEL),
        .HCS_USER      (HCS_USER),
        .HANDLER_BASE  (HANDLER_BASE),
        .HANDLER_STRIDE(HANDLER_STRIDE)
    ) u_rom (
        .vec (vec_q),
        .gate(gate_lk)
    );

    exc_word_mux u_mux (
        .kind(kind_q),
        .ctx (ctx_q),
        .wide(gate_q.is32),
        .data(push_data)
    );

    assign ring_change = (gate_lk.ring != ctx_q.cpl);
    assign kind_nx     = following_kind(kind_q, err_q);

    assign busy       = (state_q != ST_IDLE);
    assign push_valid = (state_q == ST_PUSH);
    assign push_wide  = gate_q.is32;
    assign push_addr  = sp_q - (gate_q.is32 ? STEP_WIDE : STEP_NARROW);
    assign done       = (state_q == ST_DONE);
    assign abort      = (state_q == ST_ABORT);
    assign entry_cs   = gate_q.cs;
    assign entry_eip  = gate_q.eip;
    assign out_ss     = fss_q;
    assign out_esp    = sp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            vec_q   <= '0;
            gate_q  <= '0;
            kind_q  <= K_END;
            err_q   <= 1'b0;
            sp_q    <= '0;
            fss_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vec_q          <= req_vec;
                        ctx_q.cpl      <= cur_cpl;
                        ctx_q.ss       <= cur_ss;
                        ctx_q.esp      <= cur_esp;
                        ctx_q.eflags   <= cur_eflags;
                        ctx_q.cs       <= cur_cs;
                        ctx_q.eip      <= cur_eip;
                        ctx_q.errcode  <= {err_idx, err_ti, err_int, err_ext};
                        ctx_q.ext      <= err_ext;
                        ctx_q.nss      <= new_ss;
                        ctx_q.nsp      <= new_sp;
                        state_q        <= ST_RESOLVE;
                    end
                end
                ST_RESOLVE: begin
                    if (!gate_lk.present) begin
                        if (vec_q == GP_VEC) begin
                            state_q <= ST_ABORT;
                        end else begin
                            ctx_q.errcode <= missing_gate_code(vec_q, ctx_q.ext);
                            vec_q         <= GP_VEC;
                        end
                    end else begin
                        gate_q  <= gate_lk;
                        err_q   <= carries_errcode(vec_q);
                        sp_q    <= ring_change ? ctx_q.nsp : ctx_q.esp;
                        fss_q   <= ring_change ? ctx_q.nss : ctx_q.ss;
                        kind_q  <= ring_change ? K_SS : K_FLAGS;
                        state_q <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    sp_q   <= push_addr;
                    kind_q <= kind_nx;
                    if (kind_nx == K_END) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/exc_frame_seq_chk.sv
module exc_frame_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        busy,
    input logic        push_valid,
    input logic        push_wide,
    input logic [31:0] push_addr,
    input logic        done,
    input logic        abort
);
    AST_PUSH_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        push_valid |-> busy); // R9

    AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
        (push_valid && $past(push_valid)) |->
            (push_addr == $past(push_addr) - (push_wide ? 32'd4 : 32'd2))); // R3

    AST_WIDTH_STEADY: assert property (@(posedge clk) disable iff (rst)
        (push_valid && $past(push_valid)) |-> $stable(push_wide)); // R4

    AST_DONE_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(push_valid)); // R1

    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (rst)
        abort |-> (!push_valid && !done && !$past(push_valid))); // R8

    AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        (done || abort) |=> !busy); // R9

    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid)); // R9
endmodule

bind exc_frame_seq exc_frame_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .push_valid(push_valid),
    .push_wide (push_wide),
    .push_addr (push_addr),
    .done      (done),
    .abort     (abort)
);

// File: tb/exc_frame_seq_test.sv
module exc_frame_seq_test;
    localparam logic [255:0] ABS_M = (256'd1 << 8'h05) | (256'd1 << 8'h14) | (256'd1 << 8'h30);
    localparam logic [255:0] NAR_M = (256'd1 << 8'h03) | (256'd1 << 8'h0B) | (256'd1 << 8'h0C)
                                   | (256'd1 << 8'h11) | (256'd1 << 8'h0D);
    localparam logic [255:0] USR_M = (256'd1 << 8'h04) | (256'd1 << 8'h0C) | (256'd1 << 8'h0E)
                                   | (256'd1 << 8'h13);
    localparam logic [255:0] ABS_B = (256'd1 << 8'h0D) | (256'd1 << 8'h06);
    localparam logic [15:0]  HCS0  = 16'h0008;
    localparam logic [15:0]  HCS3  = 16'h001B;
    localparam logic [31:0]  HBASE = 32'h0000_4000;
    localparam logic [31:0]  HSTR  = 32'h0000_0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_b = 1'b0;
    logic [7:0]  req_vec = '0;
    logic [1:0]  cur_cpl = '0;
    logic [15:0] cur_ss = '0, cur_cs = '0, new_ss = '0;
    logic [31:0] cur_esp = '0, cur_eflags = '0, cur_eip = '0, new_sp = '0;
    logic [12:0] err_idx = '0;
    logic        err_ti = 1'b0, err_int = 1'b0, err_ext = 1'b0;

    logic        busy, push_valid, push_wide, done, abort;
    logic [31:0] push_addr, push_data, entry_eip, out_esp;
    logic [15:0] entry_cs, out_ss;
    logic        b_busy, b_pv, b_pw, b_done, b_abort;
    logic [31:0] b_pa, b_pd, b_eip, b_esp;
    logic [15:0] b_cs, b_ss;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    exc_frame_seq #(
        .ABSENT_MASK(ABS_M), .NARROW_MASK(NAR_M), .USER_MASK(USR_M),
        .HCS_KERNEL(HCS0), .HCS_USER(HCS3), .HANDLER_BASE(HBASE), .HANDLER_STRIDE(HSTR)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vec(req_vec), .cur_cpl(cur_cpl),
        .cur_ss(cur_ss), .cur_esp(cur_esp), .cur_eflags(cur_eflags), .cur_cs(cur_cs),
        .cur_eip(cur_eip), .err_idx(err_idx), .err_ti(err_ti), .err_int(err_int),
        .err_ext(err_ext), .new_ss(new_ss), .new_sp(new_sp), .busy(busy),
        .push_valid(push_valid), .push_wide(push_wide), .push_addr(push_addr),
        .push_data(push_data), .done(done), .abort(abort), .entry_cs(entry_cs),
        .entry_eip(entry_eip), .out_ss(out_ss), .out_esp(out_esp)
    );

    exc_frame_seq #(
        .ABSENT_MASK(ABS_B), .HCS_KERNEL(HCS0), .HCS_USER(HCS3),
        .HANDLER_BASE(HBASE), .HANDLER_STRIDE(HSTR)
    ) uut_b (
        .clk(clk), .rst(rst), .req_valid(req_b), .req_vec(req_vec), .cur_cpl(cur_cpl),
        .cur_ss(cur_ss), .cur_esp(cur_esp), .cur_eflags(cur_eflags), .cur_cs(cur_cs),
        .cur_eip(cur_eip), .err_idx(err_idx), .err_ti(err_ti), .err_int(err_int),
        .err_ext(err_ext), .new_ss(new_ss), .new_sp(new_sp), .busy(b_busy),
        .push_valid(b_pv), .push_wide(b_pw), .push_addr(b_pa),
        .push_data(b_pd), .done(b_done), .abort(b_abort), .entry_cs(b_cs),
        .entry_eip(b_eip), .out_ss(b_ss), .out_esp(b_esp)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_inputs(input logic [7:0] v, input logic [1:0] cpl);
        req_vec    = v;
        cur_cpl    = cpl;
        cur_ss     = 16'h0010 + 16'(v);
        cur_esp    = 32'h0001_8000 + 32'(v) * 32'd16;
        cur_eflags = 32'h0004_0202 ^ 32'(v);
        cur_cs     = 16'h0023;
        cur_eip    = 32'h0012_0000 + 32'(v) * 32'd3;
        err_idx    = 13'h0A50 ^ 13'(v);
        err_ti     = v[0];
        err_int    = v[1];
        err_ext    = v[2];
        new_ss     = 16'h0030;
        new_sp     = 32'h0009_F000;
    endtask

    // Runs one request on uut and compares against a model built from R1-R11.
    task automatic run_frame(input logic [7:0] v, input logic [1:0] cpl, input logic poke);
        logic [31:0] exp_w [6];
        logic [31:0] got_w [8];
        logic [31:0] got_a [8];
        int          n, got, cyc;
        logic        redir, wide, chg, has_err, busy_ok, seen_done;
        logic [7:0]  rv;
        logic [1:0]  hring;
        logic [15:0] ecode;
        logic [31:0] mask, step, sp0, exp_eip;
        set_inputs(v, cpl);
        redir   = ABS_M[v];
        rv      = redir ? 8'h0D : v;
        wide    = !NAR_M[rv];
        hring   = USR_M[rv] ? 2'd3 : 2'd0;
        chg     = (hring != cpl);
        has_err = (rv == 8'h08) || (rv >= 8'h0A && rv <= 8'h0E);
        ecode   = redir ? {5'b0, v, 1'b0, 1'b1, err_ext} : {err_idx, err_ti, err_int, err_ext};
        mask    = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        step    = wide ? 32'd4 : 32'd2;
        sp0     = chg ? new_sp : cur_esp;
        exp_eip = cur_eip;
        n = 0;
        if (chg) begin
            exp_w[n] = {16'h0, cur_ss}; n++;
            exp_w[n] = cur_esp & mask;  n++;
        end
        exp_w[n] = cur_eflags & mask; n++;
        exp_w[n] = {16'h0, cur_cs};   n++;
        exp_w[n] = exp_eip & mask;    n++;
        if (has_err) begin exp_w[n] = {16'h0, ecode}; n++; end

        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        got = 0; busy_ok = 1'b1; seen_done = 1'b0;
        for (int c = 0; c < 20; c++) begin
            cyc = c;
            if (poke && c == 0) begin
                set_inputs(8'h00, 2'd0);
                req_valid = 1'b1;
            end
            if (poke && c == 2) req_valid = 1'b0;
            if (!busy) busy_ok = 1'b0;
            if (push_valid && got < 8) begin
                got_w[got] = push_data;
                got_a[got] = push_addr;
                chk(push_wide == wide, "R4 push width", 32'(push_wide), 32'(wide));
                got++;
            end
            if (done) begin seen_done = 1'b1; break; end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(seen_done, "R1 done reached", 32'(seen_done), 32'd1);
        chk(busy_ok, poke ? "R9 busy held under competing request" : "R9 busy held",
            32'(busy_ok), 32'd1);
        chk(got == n, has_err ? "R2 word count with error code" : "R2 word count without error code",
            32'(got), 32'(n));
        for (int k = 0; k < n && k < got; k++) begin
            chk(got_w[k] == exp_w[k],
                (redir && k == n - 1) ? "R6 redirect word" :
                (chg && k < 2) ? "R5 old stack word" : "R1 frame word",
                got_w[k], exp_w[k]);
            chk(got_a[k] == sp0 - step * 32'(k + 1), "R3 push address",
                got_a[k], sp0 - step * 32'(k + 1));
        end
        if (got == n && n >= 3) begin
            chk(got_w[chg ? 4 : 2] == (exp_eip & mask), "R11 saved EIP",
                got_w[chg ? 4 : 2], exp_eip & mask);
            if (has_err && !redir)
                chk(got_w[n-1] == {16'h0, ecode}, "R7 error code fields", got_w[n-1], 32'(ecode));
        end
        chk(out_esp == sp0 - step * 32'(n), "R3 final stack pointer", out_esp, sp0 - step * 32'(n));
        chk(out_ss == (chg ? new_ss : cur_ss), "R5 frame stack segment",
            32'(out_ss), 32'(chg ? new_ss : cur_ss));
        chk(entry_cs == (hring == 2'd3 ? HCS3 : HCS0), "R10 entry cs",
            32'(entry_cs), 32'(hring == 2'd3 ? HCS3 : HCS0));
        chk(entry_eip == HBASE + 32'(rv) * HSTR, "R10 entry eip", entry_eip, HBASE + 32'(rv) * HSTR);
        @(negedge clk);
        chk(!busy, "R9 idle after done", 32'(busy), 32'd0);
        if (cyc > 18) $display("note: long run for vector %h", v);
    endtask

    task automatic run_abort(input logic [7:0] v);
        logic saw_abort, saw_push, saw_done;
        set_inputs(v, 2'd0);
        req_b = 1'b1;
        @(negedge clk);
        req_b = 1'b0;
        saw_abort = 1'b0; saw_push = 1'b0; saw_done = 1'b0;
        for (int c = 0; c < 8; c++) begin
            if (b_pv) saw_push = 1'b1;
            if (b_done) saw_done = 1'b1;
            if (b_abort) begin saw_abort = 1'b1; break; end
            @(negedge clk);
        end
        chk(saw_abort, "R8 abort raised", 32'(saw_abort), 32'd1);
        chk(!saw_push && !saw_done, "R8 no push or done", 32'({saw_push, saw_done}), 32'd0);
        @(negedge clk);
        chk(!b_busy && !b_abort, "R8 idle after abort", 32'({b_busy, b_abort}), 32'd0);
    endtask

    task automatic check_reset;
        chk(!busy && !push_valid && !done && !abort, "R12 reset outputs",
            32'({busy, push_valid, done, abort}), 32'd0);
        chk(!b_busy && !b_pv && !b_done && !b_abort, "R12 reset outputs second",
            32'({b_busy, b_pv, b_done, b_abort}), 32'd0);
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst = 1'b0;
        @(negedge clk);
        check_reset();
        for (int v = 0; v < 32; v++) run_frame(8'(v), (v % 2 == 0) ? 2'd0 : 2'd3, 1'b0);
        run_frame(8'h30, 2'd3, 1'b0);
        run_frame(8'h0E, 2'd0, 1'b1);
        run_frame(8'h13, 2'd3, 1'b0);
        run_abort(8'h0D);
        run_abort(8'h06);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule